// File: doc/BRIEF.md
# One-Hot-Plus-Zero Serial Arithmetic Sequencer

This block is the control state machine for an eight-bit adder/subtractor that works one bit per clock. A pushbutton request, already debounced, starts one operation. The sequencer first loads the external bit counter and clears the result register. It then enables shifting until the counter reports that eight bits have been handled, flags completion, and waits for the request to be released before it re-arms. One press therefore gives exactly one operation. An add/subtract select is passed to the datapath as a conditional output that is valid only in the load phase. The datapath uses it to force the carry-in high and invert the second operand.

The state is kept in four flip-flops. The all-zero code is the idle state. Each working state owns one flip-flop: bit 0 is load/clear, bit 1 is operate, bit 2 is done and bit 3 is release-wait. A move from one working state to the next takes one extra cycle in which both the origin and the destination bits are set. The origin bit is dropped only after the destination bit is in place. Unconditional outputs are single state bits with no decoding. The conditional output is one input ANDed with one state bit. The register is brought out on `state_q` so that the encoding can be observed.

Top module: `ohz_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state register becomes 0000 and stays there whatever `start` does. In that state `load_cnt_n` and `clear_acc_n` are 1 and `shift_en`, `done` and `sub_mode` are 0.
- R2: In idle (0000), a rising edge with `start` high moves the state to 0001 (load/clear). With `start` low the state stays 0000.
- R3: The state code never has three or more bits set.
- R4: Every move between working states passes through the two-bit code made of origin and destination for exactly one cycle (0011, 0110, 1100), and a two-bit code is never followed by 0000.
- R5: `load_cnt_n` and `clear_acc_n` are low exactly when state bit 0 is set, and high otherwise.
- R6: `shift_en` equals state bit 1. In operate (0010) the state holds until `cnt_full` is high, then goes to 0110. `cnt_full` has no effect in any other state.
- R7: `done` equals state bit 2. Done (0100) always goes on to 1100 and then to release-wait (1000).
- R8: Release-wait (1000) holds while `start` is high and returns to 0000 on the first edge with `start` low.
- R9: `sub_mode` equals `sub_sel` AND state bit 0, and it follows `sub_sel` within the same cycle without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low sanity reset |
| start | input | 1 | Debounced operation request |
| sub_sel | input | 1 | 1 selects subtract, 0 selects add |
| cnt_full | input | 1 | High when the external bit counter has reached eight |
| load_cnt_n | output | 1 | Active-low load of the bit counter |
| clear_acc_n | output | 1 | Active-low clear of the result register |
| shift_en | output | 1 | Shift/operate enable for the serial datapath |
| done | output | 1 | Operation complete |
| sub_mode | output | 1 | Conditional subtract-mode strobe |
| state_q | output | 4 | Current state code |

## Verification
The bench goes after the hand-over cycles. A design that skipped the overlap would jump straight between one-hot codes, and one that dropped the origin bit too early would show 0000 in the middle of an operation. It asserts `cnt_full` during the load-to-operate overlap and holds it low for a long stretch in operate. A design that sampled the flag outside the exact operate code would finish early, and one that ignored it would hang. It keeps `start` held through done, which catches a design that re-arms at once and starts a second operation. It toggles `sub_sel` between clock edges, which catches a registered strobe or one that is not gated by the load bit. It also pulls the sanity reset during operate to show that the register returns to idle.

// File: rtl/ohz_pkg.sv
// Package: shared widths, state bit positions and legal state codes for the
// one-hot-plus-zero sequencer. Assumes a four-bit register with idle = 0000.
package ohz_pkg;

    localparam int unsigned ST_W = 4;

    // Bit ownership of each working state.
    localparam int unsigned B_LOAD = 0;
    localparam int unsigned B_OPER = 1;
    localparam int unsigned B_DONE = 2;
    localparam int unsigned B_HOLD = 3;

    typedef logic [ST_W-1:0] st_t;

    // Steady codes.
    localparam st_t C_IDLE = 4'b0000;
    localparam st_t C_LOAD = 4'b0001;
    localparam st_t C_OPER = 4'b0010;
    localparam st_t C_DONE = 4'b0100;
    localparam st_t C_HOLD = 4'b1000;

    // Hand-over codes: origin and destination set together.
    localparam st_t C_L2O = 4'b0011;
    localparam st_t C_O2D = 4'b0110;
    localparam st_t C_D2H = 4'b1100;

endpackage

// File: rtl/ohz_next.sv
// Module: next-state logic. Each steady working state first sets its
// successor's bit while keeping its own, and clears its own bit one cycle
// later. Any code outside the legal set falls back to idle.
// Assumes start is already debounced and cnt_full is synchronous to clk.
module ohz_next
    import ohz_pkg::*;
(
    input  st_t  cur,
    input  logic start,
    input  logic cnt_full,
    output st_t  nxt
);

    // Purpose: choose the next code from the current code and the inputs.
    always_comb begin
        unique case (cur)
            C_IDLE:  nxt = start ? C_LOAD : C_IDLE;
            C_LOAD:  nxt = C_L2O;
            C_L2O:   nxt = C_OPER;
            C_OPER:  nxt = cnt_full ? C_O2D : C_OPER;
            C_O2D:   nxt = C_DONE;
            C_DONE:  nxt = C_D2H;
            C_D2H:   nxt = C_HOLD;
            C_HOLD:  nxt = start ? C_HOLD : C_IDLE;
            default: nxt = C_IDLE;
        endcase
    end

endmodule

// File: rtl/ohz_state_reg.sv
// Module: the state register, one flip-flop per state bit, with a
// synchronous active-low sanity reset to the all-zero idle code.
module ohz_state_reg
    import ohz_pkg::*;
#(
    parameter int unsigned WIDTH = ST_W
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Purpose: hold one state bit, cleared by the sanity reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
        end
    end

endmodule

// File: rtl/ohz_outputs.sv
// Module: output forming. Unconditional outputs are single state bits;
// the conditional subtract strobe is one input ANDed with one state bit.
// Assumes the load bit drives both active-low strobes.
module ohz_outputs
    import ohz_pkg::*;
(
    input  st_t  q,
    input  logic sub_sel,
    output logic load_cnt_n,
    output logic clear_acc_n,
    output logic shift_en,
    output logic done,
    output logic sub_mode
);

    // Purpose: unconditional outputs taken straight from state bits.
    always_comb begin
        load_cnt_n  = ~q[B_LOAD];
        clear_acc_n = ~q[B_LOAD];
        shift_en    = q[B_OPER];
        done        = q[B_DONE];
    end

    // Purpose: conditional strobe, valid in the same cycle as sub_sel.
    always_comb sub_mode = sub_sel & q[B_LOAD];

endmodule

// File: rtl/ohz_ctrl.sv
// Module: top of the one-hot-plus-zero serial adder/subtractor sequencer.
// Connects next-state logic, state register and output forming, and
// carries the assertions on the encoding and sequencing.
module ohz_ctrl
    import ohz_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            sub_sel,
    input  logic            cnt_full,
    output logic            load_cnt_n,
    output logic            clear_acc_n,
    output logic            shift_en,
    output logic            done,
    output logic            sub_mode,
    output logic [ST_W-1:0] state_q
);

    st_t cur;
    st_t nxt;

    ohz_next u_next (
        .cur      (cur),
        .start    (start),
        .cnt_full (cnt_full),
        .nxt      (nxt)
    );

    ohz_state_reg #(.WIDTH(ST_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (cur)
    );

    ohz_outputs u_out (
        .q           (cur),
        .sub_sel     (sub_sel),
        .load_cnt_n  (load_cnt_n),
        .clear_acc_n (clear_acc_n),
        .shift_en    (shift_en),
        .done        (done),
        .sub_mode    (sub_mode)
    );

    always_comb state_q = cur;

    AST_SANITY_CLEARS: assert property (@(posedge clk) !rst_n |=> cur == C_IDLE); // R1
    AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == C_IDLE && start) |=> cur == C_LOAD); // R2
    AST_MAX_TWO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cur) <= 2); // R3
    AST_OVERLAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cur) == 2) |=> cur != C_IDLE); // R4
    AST_OPER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == C_OPER && !cnt_full) |=> cur == C_OPER); // R6
    AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(shift_en)); // R7
    AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == C_HOLD && start) |=> cur == C_HOLD); // R8

endmodule

// File: tb/ohz_ctrl_bench.sv
// Bench: table-driven walk through two operations, then directed tests for
// the same-cycle subtract strobe, a long operate wait and a mid-run reset.
module ohz_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       sub_sel = 1'b0;
    logic       cnt_full = 1'b0;
    logic       load_cnt_n, clear_acc_n, shift_en, done, sub_mode;
    logic [3:0] state_q;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ohz_ctrl u_ohz_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .sub_sel     (sub_sel),
        .cnt_full    (cnt_full),
        .load_cnt_n  (load_cnt_n),
        .clear_acc_n (clear_acc_n),
        .shift_en    (shift_en),
        .done        (done),
        .sub_mode    (sub_mode),
        .state_q     (state_q)
    );

    // Row: {start, sub_sel, cnt_full, state, load_n, clear_n, shift, done, sub}
    localparam int NV = 20;
    localparam logic [11:0] VEC [NV] = '{
        12'b010_0000_11000, // R2 idle stays, R9 no strobe in idle
        12'b110_0001_00001, // R2 R5 R9 load entry
        12'b110_0011_00101, // R4 load->operate overlap
        12'b100_0010_11100, // R6 operate
        12'b000_0010_11100, // R6 waiting for count
        12'b001_0110_11110, // R4 R6 operate->done overlap
        12'b000_0100_11010, // R7 done
        12'b100_1100_11010, // R4 R7 done->hold overlap
        12'b100_1000_11000, // R8 hold
        12'b100_1000_11000, // R8 still held
        12'b000_0000_11000, // R8 release to idle
        12'b000_0000_11000, // R2 idle
        12'b100_0001_00000, // R2 R9 add operation
        12'b010_0011_00101, // R9 strobe follows select
        12'b011_0010_11100, // R6 cnt_full ignored in overlap
        12'b001_0110_11110, // R6
        12'b000_0100_11010, // R7
        12'b000_1100_11010, // R7
        12'b000_1000_11000, // R7 R8
        12'b000_0000_11000  // R8
    };

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [3:0] st,
                              input logic [4:0] o);
        check(req, "state", state_q, st);
        check(req, "outputs", {load_cnt_n, clear_acc_n, shift_en, done},
              o[4:1]);
        check(req, "sub_mode", {3'b000, sub_mode}, {3'b000, o[0]});
        check("R3", "at most two ones", {3'b000, ($countones(state_q) <= 2)},
              4'b0001);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0] prev;
        // R1: reset state, with start held high during reset.
        start = 1'b1;
        repeat (3) @(posedge clk);
        #1 check_outs("R1", 4'b0000, 5'b11000);
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b1;
        prev = 4'b0000;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {start, sub_sel, cnt_full} = VEC[i][11:9];
            @(posedge clk);
            #1;
            check_outs($sformatf("row%0d", i), VEC[i][8:5], VEC[i][4:0]);
            if ($countones(prev) == 2)
                check("R4", "no zero after overlap",
                      {3'b000, (state_q != 4'b0000)}, 4'b0001);
            prev = state_q;
        end

        // R9: strobe follows sub_sel within the load cycle.
        @(negedge clk);
        {start, sub_sel, cnt_full} = 3'b100;
        @(posedge clk);
        #1 check_outs("R2", 4'b0001, 5'b00000);
        @(negedge clk);
        sub_sel = 1'b1;
        #1 check("R9", "sub_mode same cycle", {3'b000, sub_mode}, 4'b0001);
        sub_sel = 1'b0;
        #1 check("R9", "sub_mode drops", {3'b000, sub_mode}, 4'b0000);
        start = 1'b0;

        // R6: long wait in operate with cnt_full low.
        repeat (2) @(posedge clk);
        #1 check_outs("R6", 4'b0010, 5'b11100);
        repeat (12) @(posedge clk);
        #1 check_outs("R6", 4'b0010, 5'b11100);

        // R1: sanity reset in the middle of operate.
        @(negedge clk);
        rst_n = 1'b0;
        cnt_full = 1'b1;
        @(posedge clk);
        #1 check_outs("R1", 4'b0000, 5'b11000);
        @(negedge clk);
        rst_n = 1'b1;
        cnt_full = 1'b0;
        @(posedge clk);
        #1 check_outs("R2", 4'b0000, 5'b11000);

        finish_run();
    end

endmodule